// File: doc/BRIEF.md
# Levelized Scan Test Controller

This block runs the structural test of a multi-level AND-EXOR network that has been cut into levels, with mux-based scan cells placed on the outputs of the internal planes. Levels are tested one at a time, in ascending order. All planes of a level are tested together by one vector. The controller addresses an external vector source by level and vector index, and drives the primary-input test vector. It also drives a two-bit mode code shared by every scan cell and one serial scan-in bit, and it reads one serial scan-out bit.

A vector for the first level comes only from the primary inputs, so it is applied at once with no scan load. A vector for an internal level is built from primary-input bits plus scan-cell bits. Those scan bits are first shifted into the chain, then held steady while the level settles. Every vector then has its plane results captured into the chain and shifted back out, and the unloaded word is reported together with its level and vector index. In normal operation each scan cell is one multiplexer in the data path.

Top module: `levelized_scan_ctrl`

## Requirements
- R1: While reset is high and after it falls, scan_mode is 00, busy, done and res_valid are 0, and pi_drive and scan_si are 0.
- R2: A start pulse seen while idle begins a run, and busy goes high on the next clock. A start pulse seen while busy has no effect on the sequence, on the results or on the run length.
- R3: Vectors run level 0 first, then level 1 and upward; within a level they run in ascending index order. Each vector's result carries res_level and res_index equal to the source address used for it.
- R4: Mode codes on scan_mode are 00 normal (idle), 01 shift, 10 capture and 11 hold. The hold code keeps the scan cells driving their stored bits to the next level.
- R5: A level-0 vector has no load shift. The controller goes fetch, one hold clock, one capture clock, then SCAN_LEN unload clocks.
- R6: An internal-level vector starts with a load of exactly SCAN_LEN shift clocks, sending src_scan bit SCAN_LEN-1 first. After the load, cell k holds src_scan bit k: cell 0 is fed by scan_si and cell SCAN_LEN-1 drives scan_so.
- R7: pi_drive takes the source's primary-input vector in the fetch clock and holds it unchanged through the hold and capture clocks.
- R8: Exactly one hold clock precedes each capture clock, and capture lasts one clock.
- R9: Unload takes SCAN_LEN shift clocks right after capture. res_data bit k equals the captured content of cell k. res_valid is a one-clock pulse in the clock after the last unload shift.
- R10: done rises together with the last result and stays high, with busy low, until the next accepted start clears it. A run keeps busy high for VEC_PER_LEVEL*(SCAN_LEN+3) + (NUM_LEVELS-1)*VEC_PER_LEVEL*(2*SCAN_LEN+3) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a test run (accepted only while idle) |
| src_level | output | LVL_W | Level address to the vector source |
| src_index | output | VIDX_W | Vector index address to the vector source |
| src_pi | input | PI_W | Primary-input vector from the source for the current address |
| src_scan | input | SCAN_LEN | Scan-cell stimulus from the source for the current address |
| pi_drive | output | PI_W | Primary-input vector driven into the network |
| scan_mode | output | 2 | Scan cell mode: 00 normal, 01 shift, 10 capture, 11 hold |
| scan_si | output | 1 | Serial data into scan cell 0 |
| scan_so | input | 1 | Serial data out of the last scan cell |
| res_data | output | SCAN_LEN | Unloaded plane results, bit k from cell k |
| res_valid | output | 1 | One-clock pulse marking a new result |
| res_level | output | LVL_W | Level of the reported result |
| res_index | output | VIDX_W | Vector index of the reported result |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last level has finished |

## Verification
For a level-0 vector, res_valid rises SCAN_LEN+3 clocks after the vector's fetch clock begins. For an internal-level vector it rises 2*SCAN_LEN+3 clocks after, and the scan chain holds the loaded stimulus in the hold clock that follows the SCAN_LEN-th load shift. The bench models the scan chain and a plane function of its own, and a driver task queues the expected level, index and word for every vector before start. A monitor samples on the falling edge and pops one entry per res_valid, so a result that comes early, late, extra or missing breaks the match. The busy-clock total and the count of clocks in each mode are compared with figures derived from SCAN_LEN, the level count and the vectors per level.

// File: rtl/lst_pkg.sv
package lst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FETCH  = 3'd1,
    ST_LOAD   = 3'd2,
    ST_APPLY  = 3'd3,
    ST_CAPT   = 3'd4,
    ST_UNLOAD = 3'd5
  } lst_state_e;

  localparam logic [1:0] MODE_NORMAL  = 2'b00;
  localparam logic [1:0] MODE_SHIFT   = 2'b01;
  localparam logic [1:0] MODE_CAPTURE = 2'b10;
  localparam logic [1:0] MODE_HOLD    = 2'b11;

  function automatic logic [1:0] mode_of(input lst_state_e s);
    case (s)
      ST_LOAD, ST_UNLOAD: mode_of = MODE_SHIFT;
      ST_CAPT:            mode_of = MODE_CAPTURE;
      ST_APPLY:           mode_of = MODE_HOLD;
      default:            mode_of = MODE_NORMAL;
    endcase
  endfunction

endpackage

// File: rtl/lst_fsm.sv
module lst_fsm
  import lst_pkg::*;
#(
  parameter int NUM_LEVELS    = 3,
  parameter int VEC_PER_LEVEL = 4,
  parameter int SCAN_LEN      = 6,
  parameter int LVL_W         = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1,
  parameter int VIDX_W        = (VEC_PER_LEVEL > 1) ? $clog2(VEC_PER_LEVEL) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output lst_state_e        state_q,
  output logic [1:0]        mode_q,
  output logic [LVL_W-1:0]  level_q,
  output logic [VIDX_W-1:0] index_q,
  output logic              shift_last,
  output logic              busy_q,
  output logic              done_q
);

  localparam int CNT_W = $clog2(SCAN_LEN + 1);

  lst_state_e       state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             shift_st;
  logic             cnt_last;
  logic             vec_last;
  logic             lvl_last;
  logic             run_last;
  logic             start_ok;

  assign shift_st   = (state_q == ST_LOAD) || (state_q == ST_UNLOAD);
  assign cnt_last   = (cnt_q == CNT_W'(SCAN_LEN - 1));
  assign vec_last   = (index_q == VIDX_W'(VEC_PER_LEVEL - 1));
  assign lvl_last   = (level_q == LVL_W'(NUM_LEVELS - 1));
  assign run_last   = vec_last && lvl_last;
  assign shift_last = shift_st && cnt_last;
  assign start_ok   = (state_q == ST_IDLE) && start;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (start) state_d = ST_FETCH;
      ST_FETCH:  state_d = (level_q == '0) ? ST_APPLY : ST_LOAD;
      ST_LOAD:   if (cnt_last) state_d = ST_APPLY;
      ST_APPLY:  state_d = ST_CAPT;
      ST_CAPT:   state_d = ST_UNLOAD;
      ST_UNLOAD: if (cnt_last) state_d = run_last ? ST_IDLE : ST_FETCH;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_NORMAL;
      cnt_q   <= '0;
      level_q <= '0;
      index_q <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_of(state_d);
      busy_q  <= (state_d != ST_IDLE);
      if (shift_st) cnt_q <= cnt_last ? '0 : cnt_q + 1'b1;
      if (start_ok) done_q <= 1'b0;
      if ((state_q == ST_UNLOAD) && cnt_last) begin
        if (run_last) begin
          level_q <= '0;
          index_q <= '0;
          done_q  <= 1'b1;
        end else if (vec_last) begin
          index_q <= '0;
          level_q <= level_q + 1'b1;
        end else begin
          index_q <= index_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/lst_scan_port.sv
module lst_scan_port
  import lst_pkg::*;
#(
  parameter int PI_W     = 8,
  parameter int SCAN_LEN = 6,
  parameter int LVL_W    = 2,
  parameter int VIDX_W   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  lst_state_e          state_q,
  input  logic                shift_last,
  input  logic [LVL_W-1:0]    level,
  input  logic [VIDX_W-1:0]   index,
  input  logic [PI_W-1:0]     src_pi,
  input  logic [SCAN_LEN-1:0] src_scan,
  input  logic                scan_so,
  output logic [PI_W-1:0]     pi_q,
  output logic                scan_si,
  output logic [SCAN_LEN-1:0] res_q,
  output logic                res_valid_q,
  output logic [LVL_W-1:0]    res_level_q,
  output logic [VIDX_W-1:0]   res_index_q
);

  logic [SCAN_LEN-1:0] sreg_q;
  logic [SCAN_LEN-1:0] shifted;
  logic                unload_end;

  // Outgoing bit leaves from the top; returning bit enters at the bottom.
  assign shifted    = {sreg_q[SCAN_LEN-2:0], scan_so};
  assign scan_si    = sreg_q[SCAN_LEN-1];
  assign unload_end = (state_q == ST_UNLOAD) && shift_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q      <= '0;
      pi_q        <= '0;
      res_q       <= '0;
      res_valid_q <= 1'b0;
      res_level_q <= '0;
      res_index_q <= '0;
    end else begin
      res_valid_q <= unload_end;
      if (state_q == ST_FETCH) begin
        pi_q   <= src_pi;
        sreg_q <= src_scan;
      end else if ((state_q == ST_LOAD) || (state_q == ST_UNLOAD)) begin
        sreg_q <= shifted;
      end
      if (unload_end) begin
        res_q       <= shifted;
        res_level_q <= level;
        res_index_q <= index;
      end
    end
  end

endmodule

// File: rtl/levelized_scan_ctrl.sv
module levelized_scan_ctrl
  import lst_pkg::*;
#(
  parameter int NUM_LEVELS    = 3,
  parameter int VEC_PER_LEVEL = 4,
  parameter int SCAN_LEN      = 6,
  parameter int PI_W          = 8,
  localparam int LVL_W        = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1,
  localparam int VIDX_W       = (VEC_PER_LEVEL > 1) ? $clog2(VEC_PER_LEVEL) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  output logic [LVL_W-1:0]    src_level,
  output logic [VIDX_W-1:0]   src_index,
  input  logic [PI_W-1:0]     src_pi,
  input  logic [SCAN_LEN-1:0] src_scan,
  output logic [PI_W-1:0]     pi_drive,
  output logic [1:0]          scan_mode,
  output logic                scan_si,
  input  logic                scan_so,
  output logic [SCAN_LEN-1:0] res_data,
  output logic                res_valid,
  output logic [LVL_W-1:0]    res_level,
  output logic [VIDX_W-1:0]   res_index,
  output logic                busy,
  output logic                done
);

  lst_state_e state;
  logic       shift_last;

  lst_fsm #(
    .NUM_LEVELS   (NUM_LEVELS),
    .VEC_PER_LEVEL(VEC_PER_LEVEL),
    .SCAN_LEN     (SCAN_LEN),
    .LVL_W        (LVL_W),
    .VIDX_W       (VIDX_W)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .state_q   (state),
    .mode_q    (scan_mode),
    .level_q   (src_level),
    .index_q   (src_index),
    .shift_last(shift_last),
    .busy_q    (busy),
    .done_q    (done)
  );

  lst_scan_port #(
    .PI_W    (PI_W),
    .SCAN_LEN(SCAN_LEN),
    .LVL_W   (LVL_W),
    .VIDX_W  (VIDX_W)
  ) u_port (
    .clk        (clk),
    .rst        (rst),
    .state_q    (state),
    .shift_last (shift_last),
    .level      (src_level),
    .index      (src_index),
    .src_pi     (src_pi),
    .src_scan   (src_scan),
    .scan_so    (scan_so),
    .pi_q       (pi_drive),
    .scan_si    (scan_si),
    .res_q      (res_data),
    .res_valid_q(res_valid),
    .res_level_q(res_level),
    .res_index_q(res_index)
  );

endmodule

// File: rtl/lst_checker.sv
module lst_checker #(
  parameter int SCAN_LEN = 6,
  parameter int LVL_W    = 2,
  parameter int PI_W     = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done,
  input logic             res_valid,
  input logic [1:0]       scan_mode,
  input logic [PI_W-1:0]  pi_drive,
  input logic [LVL_W-1:0] src_level
);

  localparam int RUN_W = $clog2(SCAN_LEN + 2);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else     run_q <= (scan_mode == 2'b01) ? run_q + 1'b1 : '0;
  end

  AST_IDLE_NORMAL: assert property (@(posedge clk) disable iff (rst) !busy |-> scan_mode == 2'b00); // R4
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R10
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst) res_valid |=> !res_valid); // R9
  AST_HOLD_BEFORE_CAPTURE: assert property (@(posedge clk) disable iff (rst) scan_mode == 2'b10 |-> $past(scan_mode) == 2'b11); // R8
  AST_UNLOAD_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (rst) scan_mode == 2'b10 |=> scan_mode == 2'b01); // R9
  AST_SHIFT_RUN_LEN: assert property (@(posedge clk) disable iff (rst) (scan_mode != 2'b01 && run_q != '0) |-> run_q == RUN_W'(SCAN_LEN)); // R6
  AST_LEVEL0_NO_LOAD: assert property (@(posedge clk) disable iff (rst) (scan_mode == 2'b11 && src_level == '0) |-> $past(scan_mode) != 2'b01); // R5
  AST_INNER_LOADED: assert property (@(posedge clk) disable iff (rst) (scan_mode == 2'b11 && src_level != '0) |-> $past(scan_mode) == 2'b01); // R6
  AST_PI_HELD: assert property (@(posedge clk) disable iff (rst) scan_mode == 2'b11 |=> $stable(pi_drive)); // R7

endmodule

bind levelized_scan_ctrl lst_checker #(
  .SCAN_LEN(SCAN_LEN),
  .LVL_W   (LVL_W),
  .PI_W    (PI_W)
) u_lst_checker (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .res_valid(res_valid),
  .scan_mode(scan_mode),
  .pi_drive (pi_drive),
  .src_level(src_level)
);

// File: tb/levelized_scan_ctrl_bench.sv
`timescale 1ns/1ps
module levelized_scan_ctrl_bench;

  localparam int NL  = 3;
  localparam int VPL = 4;
  localparam int L   = 6;
  localparam int PIW = 8;
  localparam int LW  = 2;
  localparam int VW  = 2;
  localparam int BUSY_CYC  = VPL*(L+3) + (NL-1)*VPL*(2*L+3);
  localparam int SHIFT_CYC = VPL*L + (NL-1)*VPL*2*L;

  typedef struct packed {
    logic [7:0]   lvl;
    logic [7:0]   idx;
    logic [L-1:0] data;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [LW-1:0]  src_level;
  logic [VW-1:0]  src_index;
  logic [PIW-1:0] src_pi;
  logic [L-1:0]   src_scan;
  logic [PIW-1:0] pi_drive;
  logic [1:0]     scan_mode;
  logic           scan_si;
  logic           scan_so;
  logic [L-1:0]   res_data;
  logic           res_valid;
  logic [LW-1:0]  res_level;
  logic [VW-1:0]  res_index;
  logic           busy;
  logic           done;

  int checks = 0;
  int fails  = 0;
  int n_busy = 0, n_shift = 0, n_capt = 0, n_hold = 0;
  exp_t exp_q[$];
  logic [L-1:0] chain;

  always #10 clk = ~clk;

  levelized_scan_ctrl #(
    .NUM_LEVELS(NL), .VEC_PER_LEVEL(VPL), .SCAN_LEN(L), .PI_W(PIW)
  ) u_levelized_scan_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .src_level(src_level), .src_index(src_index),
    .src_pi(src_pi), .src_scan(src_scan),
    .pi_drive(pi_drive), .scan_mode(scan_mode),
    .scan_si(scan_si), .scan_so(scan_so),
    .res_data(res_data), .res_valid(res_valid),
    .res_level(res_level), .res_index(res_index),
    .busy(busy), .done(done)
  );

  function automatic logic [PIW-1:0] vec_pi(input int l, input int i);
    return PIW'(l*37 + i*91 + 5);
  endfunction

  function automatic logic [L-1:0] vec_scan(input int l, input int i);
    if (i == 0) return '1;
    if (i == VPL-1) return '0;
    return L'((l*13) ^ (i*29) ^ 42);
  endfunction

  function automatic logic [L-1:0] plane(input int l, input logic [PIW-1:0] p, input logic [L-1:0] s);
    if (l == 0) return ~p[L-1:0];
    return p[L-1:0] ^ {s[L-2:0], s[L-1]} ^ L'(l);
  endfunction

  // Vector source and network model: cell 0 fed by scan_si, last cell drives scan_so.
  assign src_pi   = vec_pi(int'(src_level), int'(src_index));
  assign src_scan = vec_scan(int'(src_level), int'(src_index));
  assign scan_so  = chain[L-1];

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else case (scan_mode)
      2'b01:   chain <= {chain[L-2:0], scan_si};
      2'b10:   chain <= plane(int'(src_level), pi_drive, chain);
      default: chain <= chain;
    endcase
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push_run();
    for (int l = 0; l < NL; l++)
      for (int i = 0; i < VPL; i++) begin
        exp_t e;
        e.lvl  = 8'(l);
        e.idx  = 8'(i);
        e.data = plane(l, vec_pi(l, i), vec_scan(l, i));
        exp_q.push_back(e);
      end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done();
    int k = 0;
    while (!done && k < 5000) begin
      @(negedge clk);
      k++;
    end
    if (!done) chk(1'b0, "R10", "watchdog waiting for done", 32'(k), 32'(BUSY_CYC));
    @(negedge clk);
  endtask

  // Monitor: scoreboard pop and per-phase checks
  always @(negedge clk) begin
    if (!rst) begin
      if (busy) n_busy++;
      if (scan_mode == 2'b01) n_shift++;
      if (scan_mode == 2'b10) begin
        n_capt++;
        chk(pi_drive == vec_pi(int'(src_level), int'(src_index)), "R7", "pi held in capture",
            32'(pi_drive), 32'(vec_pi(int'(src_level), int'(src_index))));
      end
      if (scan_mode == 2'b11) begin
        n_hold++;
        chk(pi_drive == vec_pi(int'(src_level), int'(src_index)), "R7", "pi in hold",
            32'(pi_drive), 32'(vec_pi(int'(src_level), int'(src_index))));
        if (src_level != '0)
          chk(chain == vec_scan(int'(src_level), int'(src_index)), "R6", "scan stimulus loaded",
              32'(chain), 32'(vec_scan(int'(src_level), int'(src_index))));
      end
      if (res_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3", "unexpected result", {res_level, res_index}, 32'hFFFF);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(res_level == e.lvl[LW-1:0] && res_index == e.idx[VW-1:0], "R3", "result order",
              32'({res_level, res_index}), 32'({e.lvl[LW-1:0], e.idx[VW-1:0]}));
          chk(res_data == e.data, "R9", "unloaded word", 32'(res_data), 32'(e.data));
        end
      end
    end
  end

  task automatic check_run(input int b0, input int s0, input int c0, input int h0);
    chk(exp_q.size() == 0, "R3", "results outstanding", 32'(exp_q.size()), 32'd0);
    chk(n_busy - b0 == BUSY_CYC, "R10", "busy clocks", 32'(n_busy - b0), 32'(BUSY_CYC));
    chk(n_shift - s0 == SHIFT_CYC, "R5", "shift clocks (no level-0 load)", 32'(n_shift - s0), 32'(SHIFT_CYC));
    chk(n_capt - c0 == NL*VPL, "R8", "capture clocks", 32'(n_capt - c0), 32'(NL*VPL));
    chk(n_hold - h0 == NL*VPL, "R8", "hold clocks", 32'(n_hold - h0), 32'(NL*VPL));
    chk(done && !busy && scan_mode == 2'b00, "R4", "idle after run", {busy, done, scan_mode}, 32'b0100);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int b0, s0, c0, h0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(scan_mode == 2'b00, "R1", "mode in reset", 32'(scan_mode), 32'd0);
    chk(!busy && !done && !res_valid, "R1", "flags in reset", {busy, done, res_valid}, 32'd0);
    chk(pi_drive == '0 && scan_si == 1'b0, "R1", "drive in reset", {pi_drive, scan_si}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && scan_mode == 2'b00, "R1", "after reset", {busy, done, scan_mode}, 32'd0);

    // Run 1 with a stray start mid-run (R2)
    push_run();
    b0 = n_busy; s0 = n_shift; c0 = n_capt; h0 = n_hold;
    pulse_start();
    chk(busy == 1'b1, "R2", "busy after start", 32'(busy), 32'd1);
    repeat (20) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_done();
    check_run(b0, s0, c0, h0);
    repeat (5) @(negedge clk);
    chk(done && !busy, "R10", "done held while idle", {busy, done}, 32'b01);

    // Run 2: done cleared by accepted start
    push_run();
    b0 = n_busy; s0 = n_shift; c0 = n_capt; h0 = n_hold;
    pulse_start();
    chk(!done && busy, "R10", "done cleared on start", {busy, done}, 32'b10);
    wait_done();
    check_run(b0, s0, c0, h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule